// File: doc/BRIEF.md
# Microcoded Byte Datapath

A single-cycle 8-bit processing element whose behaviour is set by a small writable microcode table instead of a fetched instruction stream. An external address input, typically driven by condition or state signals from neighbouring logic, picks one table entry on every rising clock edge. That entry names an ALU function, two operand sources, a post-ALU shift, whether to apply the mask, and which accumulator receives the result.

The datapath holds two accumulators, two host-written data registers, a host-written mask register and two 4-entry byte queues. The host fills the queues, and the microcode consumes them as operands. Combinational status flags report zero, all-ones, accumulator/data-register equality and signed overflow, so that surrounding logic can steer the next microcode address from them. A typical use is a reloadable counter. One entry decrements an accumulator, a second reloads it from a data register, and the zero flag of the accumulator drives the address bit that chooses between the two entries.

The datapath has no states of its own. Its whole sequencing is held in the microcode table and in the external address.

Top module: `ucode_datapath`

## Requirements
- R1: A synchronous active-high reset clears both accumulators, both data registers and every microcode entry to the all-zero word, empties both queues, clears both underflow flags and sets the mask to 0xFF. The all-zero word means "pass A0, no destination", so it changes no register.
- R2: The 14-bit microcode word is {op[13:11], srcA[10:8], srcB[7:5], shift[4:3], mask_en[2], dest[1:0]}. The entry addressed by `ustore_addr` executes at each rising edge. A host write with `host_sel`=3 stores `host_wdata` into entry `host_idx`.
- R3: ALU op encoding: 0 pass A, 1 A+1, 2 A-1, 3 A+B, 4 A-B, 5 A&B, 6 A|B, 7 A^B. All arithmetic is modulo 256.
- R4: `st_ovf` is high when the addressed entry is add (3) and A and B share a sign that differs from the sum's sign, or is subtract (4) and A and B differ in sign and the difference's sign differs from A's. It is low for every other op.
- R5: The ALU result then passes a shift stage: 0 pass, 1 left by one with 0 fill, 2 right by one with 0 fill, 3 swap of the two nibbles.
- R6: When mask_en is 1, the shifted value is ANDed with the mask register before write-back. The shift always comes before the mask.
- R7: dest encoding: 0 none, 1 A0, 2 A1, 3 both accumulators. With dest 0 both accumulators hold their values.
- R8: Operand source encoding: 0 A0, 1 A1, 2 D0, 3 D1, 4 queue 0 head, 5 queue 1 head, 6 constant 0x00, 7 constant 0xFF.
- R9: Each queue holds 4 bytes in first-in first-out order. A host push into a full queue is dropped. `fifo_head` shows the oldest byte, or 0x00 when the queue is empty. A host pop removes one byte.
- R10: A queue pops exactly one byte in any cycle where srcA or srcB selects it, even when both select it or when the op does not use that operand.
- R11: An operand read from an empty queue yields 0x00 and sets that queue's sticky `uflow` bit. The bit stays set until a `uflow_clr` pulse for that queue. A new underflow in the same cycle as a clear leaves the bit set.
- R12: `st_zero` and `st_ones` report A0, A1, D0, D1 in bits 0 to 3 equal to 0x00 or to 0xFF. `st_eq[0]` is A0==D0 and `st_eq[1]` is A1==D1.
- R13: Host writes with `host_sel` 0, 1 or 2 load `host_wdata[7:0]` into D0, D1 or the mask register. A microcode entry that reads a register sees its value from before the edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Datapath clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| ustore_addr | input | 3 | Microcode entry to execute this edge |
| host_we | input | 1 | Host write strobe |
| host_sel | input | 2 | Host write target: 0 D0, 1 D1, 2 mask, 3 microcode |
| host_idx | input | 3 | Microcode entry for a host microcode write |
| host_wdata | input | 14 | Host write data (low 8 bits for registers) |
| fifo_push | input | 2 | Host push strobe per queue |
| fifo_wdata | input | 8 | Byte to push |
| fifo_pop | input | 2 | Host pop strobe per queue |
| uflow_clr | input | 2 | Clear pulse for each underflow flag |
| acc0 | output | 8 | Accumulator A0 |
| acc1 | output | 8 | Accumulator A1 |
| fifo_head | output | 2x8 | Oldest byte of each queue, 0 when empty |
| fifo_empty | output | 2 | Queue empty |
| fifo_full | output | 2 | Queue full |
| uflow | output | 2 | Sticky underflow flag per queue |
| st_zero | output | 4 | Zero detect on A0, A1, D0, D1 |
| st_ones | output | 4 | All-ones detect on A0, A1, D0, D1 |
| st_eq | output | 2 | A0==D0, A1==D1 |
| st_ovf | output | 1 | Signed overflow of the addressed add or subtract |

## Verification
A corrupted accumulator shows on `acc0`/`acc1` and on the status flags one edge after the faulty write. A wrong microcode word or a wrong operand select shows as a wrong result on the very next executed entry. A broken queue pointer or count first shows on `fifo_head`, `fifo_empty` or `fifo_full`. It becomes visible no later than the next push or pop, and as a missing or repeated byte when the microcode drains the queue. The accumulators are reloaded from the data registers before each vector, so a fault cannot carry from one vector into the next unseen. The order of shift and mask, the single pop when both operands select one queue, and the dropped push into a full queue each get a case whose expected value differs from the value a wrong design would give.

// File: rtl/ucdp_pkg.sv
`timescale 1ns/1ps
package ucdp_pkg;

    typedef enum logic [2:0] {
        OP_PASS = 3'd0,
        OP_INC  = 3'd1,
        OP_DEC  = 3'd2,
        OP_ADD  = 3'd3,
        OP_SUB  = 3'd4,
        OP_AND  = 3'd5,
        OP_OR   = 3'd6,
        OP_XOR  = 3'd7
    } alu_op_e;

    typedef enum logic [2:0] {
        SRC_A0   = 3'd0,
        SRC_A1   = 3'd1,
        SRC_D0   = 3'd2,
        SRC_D1   = 3'd3,
        SRC_F0   = 3'd4,
        SRC_F1   = 3'd5,
        SRC_ZERO = 3'd6,
        SRC_ONES = 3'd7
    } src_e;

    typedef enum logic [1:0] {
        SH_PASS  = 2'd0,
        SH_LEFT  = 2'd1,
        SH_RIGHT = 2'd2,
        SH_SWAP  = 2'd3
    } shift_e;

    typedef enum logic [1:0] {
        DST_NONE = 2'd0,
        DST_A0   = 2'd1,
        DST_A1   = 2'd2,
        DST_BOTH = 2'd3
    } dest_e;

    typedef enum logic [1:0] {
        HT_D0     = 2'd0,
        HT_D1     = 2'd1,
        HT_MASK   = 2'd2,
        HT_USTORE = 2'd3
    } host_tgt_e;

    typedef struct packed {
        alu_op_e op;
        src_e    src_a;
        src_e    src_b;
        shift_e  shift;
        logic    mask_en;
        dest_e   dest;
    } uword_t;

    localparam int UW = $bits(uword_t);

endpackage

// File: rtl/ucdp_ustore.sv
`timescale 1ns/1ps
module ucdp_ustore
    import ucdp_pkg::*;
#(
    parameter int DEPTH = 8,
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  uword_t        wdata,
    input  logic [AW-1:0] raddr,
    output uword_t        rdata
);

    uword_t mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) begin
                mem_q[i] <= '0;
            end
        end else if (we) begin
            mem_q[waddr] <= wdata;
        end
    end

    // Asynchronous read: the addressed entry acts on the same edge.
    assign rdata = mem_q[raddr];

endmodule

// File: rtl/ucdp_fifo.sv
`timescale 1ns/1ps
module ucdp_fifo #(
    parameter int DW    = 8,
    parameter int DEPTH = 4,
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          push,
    input  logic [DW-1:0] push_data,
    input  logic          pop,
    output logic [DW-1:0] head,
    output logic          empty,
    output logic          full
);

    logic [DW-1:0] mem_q [DEPTH];
    logic [PW-1:0] rd_q, wr_q;
    logic [CW-1:0] cnt_q;
    logic          push_ok, pop_ok;

    function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign empty   = (cnt_q == '0);
    assign full    = (cnt_q == CW'(DEPTH));
    assign push_ok = push && !full;
    assign pop_ok  = pop && !empty;
    assign head    = empty ? '0 : mem_q[rd_q];

    always_ff @(posedge clk) begin
        if (push_ok) begin
            mem_q[wr_q] <= push_data;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_q  <= '0;
            wr_q  <= '0;
            cnt_q <= '0;
        end else begin
            if (push_ok) wr_q <= bump(wr_q);
            if (pop_ok)  rd_q <= bump(rd_q);
            unique case ({push_ok, pop_ok})
                2'b10:   cnt_q <= cnt_q + 1'b1;
                2'b01:   cnt_q <= cnt_q - 1'b1;
                default: cnt_q <= cnt_q;
            endcase
        end
    end

    assert_count_bound_R9: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= CW'(DEPTH));

    assert_full_push_dropped_R9: assert property (@(posedge clk) disable iff (rst)
        (full && push && !pop) |=> (full && $stable(wr_q)));

    assert_empty_pop_ignored_R11: assert property (@(posedge clk) disable iff (rst)
        (empty && pop && !push) |=> empty);

endmodule

// File: rtl/ucdp_alu.sv
`timescale 1ns/1ps
module ucdp_alu
    import ucdp_pkg::*;
#(
    parameter int DW = 8,
    localparam int HALF = DW / 2
) (
    input  alu_op_e       op,
    input  logic [DW-1:0] opnd_a,
    input  logic [DW-1:0] opnd_b,
    input  shift_e        shift,
    input  logic          mask_en,
    input  logic [DW-1:0] mask,
    output logic [DW-1:0] result,
    output logic          ovf
);

    logic [DW-1:0] alu_r;
    logic [DW-1:0] sh_r;

    always_comb begin
        unique case (op)
            OP_PASS: alu_r = opnd_a;
            OP_INC:  alu_r = opnd_a + DW'(1);
            OP_DEC:  alu_r = opnd_a - DW'(1);
            OP_ADD:  alu_r = opnd_a + opnd_b;
            OP_SUB:  alu_r = opnd_a - opnd_b;
            OP_AND:  alu_r = opnd_a & opnd_b;
            OP_OR:   alu_r = opnd_a | opnd_b;
            OP_XOR:  alu_r = opnd_a ^ opnd_b;
        endcase
    end

    always_comb begin
        unique case (op)
            OP_ADD:  ovf = (opnd_a[DW-1] == opnd_b[DW-1]) && (alu_r[DW-1] != opnd_a[DW-1]);
            OP_SUB:  ovf = (opnd_a[DW-1] != opnd_b[DW-1]) && (alu_r[DW-1] != opnd_a[DW-1]);
            default: ovf = 1'b0;
        endcase
    end

    always_comb begin
        unique case (shift)
            SH_PASS:  sh_r = alu_r;
            SH_LEFT:  sh_r = {alu_r[DW-2:0], 1'b0};
            SH_RIGHT: sh_r = {1'b0, alu_r[DW-1:1]};
            SH_SWAP:  sh_r = {alu_r[HALF-1:0], alu_r[DW-1:HALF]};
        endcase
    end

    assign result = mask_en ? (sh_r & mask) : sh_r;

endmodule

// File: rtl/ucode_datapath.sv
`timescale 1ns/1ps
module ucode_datapath
    import ucdp_pkg::*;
#(
    parameter int DW         = 8,
    parameter int US_DEPTH   = 8,
    parameter int FIFO_DEPTH = 4,
    localparam int UAW    = (US_DEPTH > 1) ? $clog2(US_DEPTH) : 1,
    localparam int NFIFO  = 2
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic [UAW-1:0]             ustore_addr,
    input  logic                       host_we,
    input  logic [1:0]                 host_sel,
    input  logic [UAW-1:0]             host_idx,
    input  logic [UW-1:0]              host_wdata,
    input  logic [NFIFO-1:0]           fifo_push,
    input  logic [DW-1:0]              fifo_wdata,
    input  logic [NFIFO-1:0]           fifo_pop,
    input  logic [NFIFO-1:0]           uflow_clr,
    output logic [DW-1:0]              acc0,
    output logic [DW-1:0]              acc1,
    output logic [NFIFO-1:0][DW-1:0]   fifo_head,
    output logic [NFIFO-1:0]           fifo_empty,
    output logic [NFIFO-1:0]           fifo_full,
    output logic [NFIFO-1:0]           uflow,
    output logic [3:0]                 st_zero,
    output logic [3:0]                 st_ones,
    output logic [1:0]                 st_eq,
    output logic                       st_ovf
);

    uword_t          uw;
    host_tgt_e       tgt;
    logic [DW-1:0]   acc0_q, acc1_q, d0_q, d1_q, mask_q;
    logic [DW-1:0]   opnd_a, opnd_b, result;
    logic [NFIFO-1:0] dp_pop;
    logic [NFIFO-1:0] uflow_q;

    assign tgt = host_tgt_e'(host_sel);

    // Microcode table
    ucdp_ustore #(.DEPTH(US_DEPTH)) u_ustore (
        .clk   (clk),
        .rst   (rst),
        .we    (host_we && (tgt == HT_USTORE)),
        .waddr (host_idx),
        .wdata (uword_t'(host_wdata)),
        .raddr (ustore_addr),
        .rdata (uw)
    );

    // Byte queues, one per queue operand source
    for (genvar gi = 0; gi < NFIFO; gi++) begin : g_fifo
        localparam src_e MY_SRC = (gi == 0) ? SRC_F0 : SRC_F1;

        assign dp_pop[gi] = (uw.src_a == MY_SRC) || (uw.src_b == MY_SRC);

        ucdp_fifo #(.DW(DW), .DEPTH(FIFO_DEPTH)) u_fifo (
            .clk       (clk),
            .rst       (rst),
            .push      (fifo_push[gi]),
            .push_data (fifo_wdata),
            .pop       (dp_pop[gi] || fifo_pop[gi]),
            .head      (fifo_head[gi]),
            .empty     (fifo_empty[gi]),
            .full      (fifo_full[gi])
        );
    end

    // Operand selection
    function automatic logic [DW-1:0] pick(input src_e s,
                                           input logic [DW-1:0] a0, a1, d0, d1, f0, f1);
        unique case (s)
            SRC_A0:   return a0;
            SRC_A1:   return a1;
            SRC_D0:   return d0;
            SRC_D1:   return d1;
            SRC_F0:   return f0;
            SRC_F1:   return f1;
            SRC_ZERO: return '0;
            SRC_ONES: return '1;
        endcase
    endfunction

    always_comb begin
        opnd_a = pick(uw.src_a, acc0_q, acc1_q, d0_q, d1_q, fifo_head[0], fifo_head[1]);
        opnd_b = pick(uw.src_b, acc0_q, acc1_q, d0_q, d1_q, fifo_head[0], fifo_head[1]);
    end

    ucdp_alu #(.DW(DW)) u_alu (
        .op      (uw.op),
        .opnd_a  (opnd_a),
        .opnd_b  (opnd_b),
        .shift   (uw.shift),
        .mask_en (uw.mask_en),
        .mask    (mask_q),
        .result  (result),
        .ovf     (st_ovf)
    );

    // Accumulator write-back
    always_ff @(posedge clk) begin
        if (rst) begin
            acc0_q <= '0;
            acc1_q <= '0;
        end else begin
            if (uw.dest == DST_A0 || uw.dest == DST_BOTH) acc0_q <= result;
            if (uw.dest == DST_A1 || uw.dest == DST_BOTH) acc1_q <= result;
        end
    end

    // Host-written registers
    always_ff @(posedge clk) begin
        if (rst) begin
            d0_q   <= '0;
            d1_q   <= '0;
            mask_q <= '1;
        end else if (host_we) begin
            unique case (tgt)
                HT_D0:     d0_q   <= host_wdata[DW-1:0];
                HT_D1:     d1_q   <= host_wdata[DW-1:0];
                HT_MASK:   mask_q <= host_wdata[DW-1:0];
                HT_USTORE: ;
            endcase
        end
    end

    // Sticky underflow: set wins over clear
    always_ff @(posedge clk) begin
        if (rst) begin
            uflow_q <= '0;
        end else begin
            uflow_q <= (uflow_q & ~uflow_clr) | (dp_pop & fifo_empty);
        end
    end

    // Outputs
    assign acc0    = acc0_q;
    assign acc1    = acc1_q;
    assign uflow   = uflow_q;
    assign st_zero = {d1_q == '0, d0_q == '0, acc1_q == '0, acc0_q == '0};
    assign st_ones = {d1_q == '1, d0_q == '1, acc1_q == '1, acc0_q == '1};
    assign st_eq   = {acc1_q == d1_q, acc0_q == d0_q};

    assert_dest_none_holds_R7: assert property (@(posedge clk) disable iff (rst)
        (uw.dest == DST_NONE) |=> ($stable(acc0_q) && $stable(acc1_q)));

    assert_ovf_only_addsub_R4: assert property (@(posedge clk) disable iff (rst)
        st_ovf |-> (uw.op == OP_ADD || uw.op == OP_SUB));

    assert_uflow_sticky_R11: assert property (@(posedge clk) disable iff (rst)
        (uflow_q[0] && !uflow_clr[0]) |=> uflow_q[0]);

    assert_empty_reads_zero_R11: assert property (@(posedge clk) disable iff (rst)
        (uw.src_a == SRC_F0 && fifo_empty[0]) |-> (opnd_a == '0));

    assert_unselected_no_uflow_R10: assert property (@(posedge clk) disable iff (rst)
        (!dp_pop[1] && !uflow_q[1]) |=> !uflow_q[1]);

endmodule

// File: tb/ucode_datapath_tb.sv
`timescale 1ns/1ps
module ucode_datapath_tb;

    localparam int NV = 16;
    localparam logic [2:0] IDLE = 3'd5;

    logic        clk = 1'b0;
    logic        rst;
    logic [2:0]  ustore_addr;
    logic        host_we;
    logic [1:0]  host_sel;
    logic [2:0]  host_idx;
    logic [13:0] host_wdata;
    logic [1:0]  fifo_push;
    logic [7:0]  fifo_wdata;
    logic [1:0]  fifo_pop;
    logic [1:0]  uflow_clr;
    logic [7:0]  acc0, acc1;
    logic [1:0][7:0] fifo_head;
    logic [1:0]  fifo_empty, fifo_full, uflow;
    logic [3:0]  st_zero, st_ones;
    logic [1:0]  st_eq;
    logic        st_ovf;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    ucode_datapath u_dut (
        .clk(clk), .rst(rst), .ustore_addr(ustore_addr),
        .host_we(host_we), .host_sel(host_sel), .host_idx(host_idx), .host_wdata(host_wdata),
        .fifo_push(fifo_push), .fifo_wdata(fifo_wdata), .fifo_pop(fifo_pop), .uflow_clr(uflow_clr),
        .acc0(acc0), .acc1(acc1), .fifo_head(fifo_head), .fifo_empty(fifo_empty),
        .fifo_full(fifo_full), .uflow(uflow), .st_zero(st_zero), .st_ones(st_ones),
        .st_eq(st_eq), .st_ovf(st_ovf)
    );

    // Vector: a0_in a1_in d0 d1 mask | op srcA srcB shift mask_en dest | exp_a0 exp_a1 exp_ovf
    localparam logic [70:0] VEC [NV] = '{
        {8'h10, 8'h20, 8'h05, 8'h00, 8'hFF, 3'd3, 3'd0, 3'd2, 2'd0, 1'b0, 2'd1, 8'h15, 8'h20, 1'b0},
        {8'h70, 8'h20, 8'h10, 8'h00, 8'hFF, 3'd3, 3'd0, 3'd2, 2'd0, 1'b0, 2'd1, 8'h80, 8'h20, 1'b1},
        {8'h00, 8'h80, 8'h00, 8'h01, 8'hFF, 3'd4, 3'd1, 3'd3, 2'd0, 1'b0, 2'd2, 8'h00, 8'h7F, 1'b1},
        {8'hFF, 8'h20, 8'h00, 8'h00, 8'hFF, 3'd1, 3'd0, 3'd0, 2'd0, 1'b0, 2'd3, 8'h00, 8'h00, 1'b0},
        {8'h33, 8'h00, 8'h00, 8'h00, 8'hFF, 3'd2, 3'd1, 3'd0, 2'd0, 1'b0, 2'd1, 8'hFF, 8'h00, 1'b0},
        {8'hF0, 8'h11, 8'h3C, 8'h00, 8'hFF, 3'd5, 3'd0, 3'd2, 2'd0, 1'b0, 2'd1, 8'h30, 8'h11, 1'b0},
        {8'h00, 8'h0F, 8'h00, 8'hA0, 8'hFF, 3'd6, 3'd1, 3'd3, 2'd0, 1'b0, 2'd2, 8'h00, 8'hAF, 1'b0},
        {8'h5A, 8'h22, 8'h00, 8'h00, 8'hFF, 3'd7, 3'd0, 3'd0, 2'd0, 1'b0, 2'd1, 8'h00, 8'h22, 1'b0},
        {8'h00, 8'h00, 8'h81, 8'h00, 8'hFF, 3'd0, 3'd2, 3'd0, 2'd1, 1'b0, 2'd1, 8'h02, 8'h00, 1'b0},
        {8'h00, 8'h00, 8'h00, 8'h81, 8'hFF, 3'd0, 3'd3, 3'd0, 2'd2, 1'b0, 2'd2, 8'h00, 8'h40, 1'b0},
        {8'h00, 8'h00, 8'hC3, 8'h00, 8'hFF, 3'd0, 3'd2, 3'd0, 2'd3, 1'b0, 2'd1, 8'h3C, 8'h00, 1'b0},
        {8'h12, 8'h00, 8'h00, 8'h34, 8'h0F, 3'd3, 3'd0, 3'd3, 2'd0, 1'b1, 2'd1, 8'h06, 8'h00, 1'b0},
        {8'h44, 8'h55, 8'h01, 8'h00, 8'hFF, 3'd3, 3'd0, 3'd2, 2'd0, 1'b0, 2'd0, 8'h44, 8'h55, 1'b0},
        {8'h00, 8'h00, 8'h00, 8'h00, 8'hFF, 3'd6, 3'd6, 3'd7, 2'd0, 1'b0, 2'd3, 8'hFF, 8'hFF, 1'b0},
        {8'h07, 8'h00, 8'h00, 8'h00, 8'hF0, 3'd1, 3'd0, 3'd0, 2'd1, 1'b1, 2'd1, 8'h10, 8'h00, 1'b0},
        {8'h05, 8'h00, 8'h07, 8'h00, 8'hFF, 3'd4, 3'd0, 3'd2, 2'd0, 1'b0, 2'd1, 8'hFE, 8'h00, 1'b0}
    };

    function automatic logic [13:0] mk(input int op, input int sa, input int sb,
                                       input int sh, input int me, input int dst);
        return {3'(op), 3'(sa), 3'(sb), 2'(sh), 1'(me), 2'(dst)};
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic host_write(input logic [1:0] sel, input logic [2:0] idx, input logic [13:0] data);
        host_we = 1'b1; host_sel = sel; host_idx = idx; host_wdata = data;
        step();
        host_we = 1'b0;
    endtask

    task automatic run(input logic [2:0] a);
        ustore_addr = a;
        step();
        ustore_addr = IDLE;
    endtask

    task automatic push(input int q, input logic [7:0] b);
        fifo_push[q] = 1'b1; fifo_wdata = b;
        step();
        fifo_push[q] = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; ustore_addr = IDLE; host_we = 1'b0; host_sel = 2'd0; host_idx = 3'd0;
        host_wdata = '0; fifo_push = '0; fifo_wdata = '0; fifo_pop = '0; uflow_clr = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        check("R1 acc0", acc0, 8'h00);
        check("R1 acc1", acc1, 8'h00);
        check("R1 fifo_empty", fifo_empty, 2'b11);
        check("R1 fifo_full", fifo_full, 2'b00);
        check("R1 uflow", uflow, 2'b00);
        check("R1 R12 st_zero", st_zero, 4'hF);
        check("R12 st_eq reset", st_eq, 2'b11);
        check("R1 st_ovf", st_ovf, 1'b0);

        // Loader entries and mask reset value
        host_write(2'd3, 3'd6, mk(0, 2, 0, 0, 0, 1));
        host_write(2'd3, 3'd7, mk(0, 3, 0, 0, 0, 2));
        host_write(2'd3, 3'd1, mk(0, 7, 0, 0, 1, 1));
        run(3'd1);
        check("R1 R6 mask resets to FF", acc0, 8'hFF);
        check("R12 st_ones A0", st_ones, 4'b0001);
        run(3'd3);
        check("R1 R2 unwritten entry is no-op acc0", acc0, 8'hFF);
        check("R1 R2 unwritten entry is no-op acc1", acc1, 8'h00);

        // Table of ALU/shift/mask/dest/source vectors (R3 R4 R5 R6 R7 R8 R13)
        for (int i = 0; i < NV; i++) begin
            logic [70:0] v;
            v = VEC[i];
            host_write(2'd0, 3'd0, {6'd0, v[70:63]});
            run(3'd6);
            host_write(2'd1, 3'd0, {6'd0, v[62:55]});
            run(3'd7);
            host_write(2'd0, 3'd0, {6'd0, v[54:47]});
            host_write(2'd1, 3'd0, {6'd0, v[46:39]});
            host_write(2'd2, 3'd0, {6'd0, v[38:31]});
            host_write(2'd3, 3'd0, v[30:17]);
            ustore_addr = 3'd0;
            #0.5;
            check($sformatf("R4 vector %0d st_ovf", i), st_ovf, v[0]);
            step();
            ustore_addr = IDLE;
            check($sformatf("R2 R3 R5 R6 R7 R8 R13 vector %0d acc0", i), acc0, v[16:9]);
            check($sformatf("R2 R3 R5 R6 R7 R8 R13 vector %0d acc1", i), acc1, v[8:1]);
        end

        // Queue entries: 1 = F0->A0, 2 = F1->A1, 4 = F0+F0->A0
        host_write(2'd3, 3'd1, mk(0, 4, 0, 0, 0, 1));
        host_write(2'd3, 3'd2, mk(0, 5, 0, 0, 0, 2));
        host_write(2'd3, 3'd4, mk(3, 4, 4, 0, 0, 1));

        push(0, 8'h11); push(0, 8'h22); push(0, 8'h33);
        check("R9 head F0", fifo_head[0], 8'h11);
        run(3'd1); check("R9 F0 order 1", acc0, 8'h11);
        run(3'd1); check("R9 F0 order 2", acc0, 8'h22);
        run(3'd1); check("R9 F0 order 3", acc0, 8'h33);
        check("R9 F0 empty", fifo_empty[0], 1'b1);
        check("R11 no uflow yet", uflow[0], 1'b0);
        run(3'd1);
        check("R11 empty read yields 0", acc0, 8'h00);
        check("R11 uflow set", uflow[0], 1'b1);
        step(); step();
        check("R11 uflow sticky", uflow[0], 1'b1);
        check("R11 other queue unaffected", uflow[1], 1'b0);
        uflow_clr[0] = 1'b1; step(); uflow_clr[0] = 1'b0;
        check("R11 uflow cleared", uflow[0], 1'b0);

        // Set wins over clear
        ustore_addr = 3'd1; uflow_clr[0] = 1'b1; step(); uflow_clr[0] = 1'b0; ustore_addr = IDLE;
        check("R11 set wins over clear", uflow[0], 1'b1);
        uflow_clr[0] = 1'b1; step(); uflow_clr[0] = 1'b0;

        // Full queue drops push
        for (int k = 1; k <= 5; k++) push(1, 8'(k));
        check("R9 F1 full", fifo_full[1], 1'b1);
        for (int k = 1; k <= 4; k++) begin
            run(3'd2);
            check($sformatf("R9 F1 drain %0d", k), acc1, 8'(k));
        end
        check("R9 fifth push dropped", fifo_empty[1], 1'b1);
        check("R9 head 0 when empty", fifo_head[1], 8'h00);

        // Both operands select one queue: one pop
        push(0, 8'h07); push(0, 8'h09);
        run(3'd4);
        check("R10 F0+F0 same byte", acc0, 8'h0E);
        check("R10 single pop", fifo_head[0], 8'h09);
        run(3'd4);
        check("R10 second byte", acc0, 8'h12);
        check("R10 no underflow", uflow[0], 1'b0);

        // Host pop
        push(1, 8'hAA); push(1, 8'hBB);
        check("R9 head AA", fifo_head[1], 8'hAA);
        fifo_pop[1] = 1'b1; step(); fifo_pop[1] = 1'b0;
        check("R9 host pop", fifo_head[1], 8'hBB);
        fifo_pop[1] = 1'b1; step(); fifo_pop[1] = 1'b0;
        check("R9 host pop empties", fifo_empty[1], 1'b1);

        // Status flags on data registers and compare
        host_write(2'd0, 3'd0, 14'h05A);
        run(3'd6);
        check("R12 st_eq A0==D0", st_eq[0], 1'b1);
        host_write(2'd0, 3'd0, 14'h05B);
        check("R12 st_eq A0!=D0", st_eq[0], 1'b0);
        host_write(2'd1, 3'd0, 14'h0FF);
        check("R12 st_ones D1", st_ones[3], 1'b1);
        check("R12 st_zero D0", st_zero[2], 1'b0);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule